// File: doc/BRIEF.md
# Down-Counting Compare Interrupt Timer

This block is a 32-bit countdown timer that software reaches through a small register bus: a byte address, a write strobe, write data and registered read data. A selectable input strobe passes through a programmable divider. Each divided tick lowers the counter by one while the timer runs. When the counter steps onto the value held in the match register, a sticky flag is raised. That flag drives the interrupt line whenever its enable bit is set.

When the count is exhausted at zero, the counter does one of two things, chosen by a control bit. It can refill from the reload register, or it can wrap to all ones and keep counting freely. Other control bits give three more actions: refill the counter at the moment the timer is enabled, copy a reload write straight into the counter, and start a short internal reset that clears the block. Software polls a status bit while that reset runs. The low-power enables and the output pin mode are only stored and read back.

Top module: `cmp_countdown_timer`

## Requirements
- R1: After the synchronous reset, every register reads 0 and the interrupt output is low.
- R2: Word addresses are control 0x00, status 0x04, reload 0x08, match 0x0C and counter 0x10. Control bit positions are: 0 run, 1 refill-on-enable, 2 interrupt enable, 3 end-of-count refill select, 15:4 divider, 16 internal reset, 17 reload write-through, 21:18 low-power enables, 23:22 pin mode, 25:24 source select. Control bits 31:26 read 0. A write to the counter has no effect. An access whose address bits 1:0 are not 00 writes nothing.
- R3: A divider value N yields one counter tick for every N+1 strobes of the selected source.
- R4: The counter changes only on a tick. A tick needs the run bit set and a strobe on the source input chosen by bits 25:24. With run clear the value holds.
- R5: With refill select at 1, a tick at count 0 loads the reload register.
- R6: With refill select at 0, a tick at count 0 gives 0xFFFFFFFF.
- R7: Status bit 0 is set on the tick whose new count equals the match register. It stays set until it is cleared.
- R8: Writing status with bit 0 at 1 clears the flag. Writing it with bit 0 at 0 leaves the flag unchanged.
- R9: The interrupt output equals (flag AND interrupt enable) as it was one cycle earlier.
- R10: A control write that turns run from 0 to 1 with refill-on-enable at 1 loads the counter from the reload register. If refill-on-enable is 0, the count is kept.
- R11: With write-through at 1, a reload write also loads that value into the counter. With write-through at 0, the counter is untouched.
- R12: A control write with bit 16 at 1 starts an internal reset lasting 4 cycles. During those cycles bit 16 reads 1 and bus writes are ignored. The reset clears the reload, match, counter and flag registers and every control field except the low-power enables and the source select, which keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the address of the previous cycle |
| src_tick | input | 4 | One count strobe per clock source |
| irq | output | 1 | Registered compare interrupt |

## Verification
A write takes effect at the clock edge that samples the strobe. Read data is registered, so it shows the state from before the edge that captures the address, and it becomes visible one edge after the address is presented. The interrupt line lags the flag by one further edge. The bench presents every input on the falling clock and samples results one unit after the rising edge that produces them. Source strobes are applied one cycle at a time, and only while the bus is idle, so each expected count follows from a known number of ticks. The reset-busy window is checked by reading control on the fourth and fifth edges after the write, using the fixed cadence of the bus tasks.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int DW    = 32;
  localparam int PRE_W = 12;
  localparam int NSRC  = 4;
  localparam int SRC_W = $clog2(NSRC);

  localparam logic [2:0] IDX_CTL   = 3'd0;
  localparam logic [2:0] IDX_STAT  = 3'd1;
  localparam logic [2:0] IDX_LOAD  = 3'd2;
  localparam logic [2:0] IDX_MATCH = 3'd3;
  localparam logic [2:0] IDX_COUNT = 3'd4;

  // Control word, most significant field first; positions are software visible.
  typedef struct packed {
    logic [5:0]       pad;
    logic [SRC_W-1:0] src;
    logic [1:0]       pin;
    logic [3:0]       lowpwr;
    logic             wthru;
    logic             srst;
    logic [PRE_W-1:0] div;
    logic             rsel;
    logic             ie;
    logic             emod;
    logic             run;
  } ctl_t;
endpackage

// File: rtl/cdt_prescale.sv
module cdt_prescale
  import cdt_pkg::*;
#(
  parameter int PW = PRE_W,
  parameter int NS = NSRC,
  localparam int SW = $clog2(NS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [SW-1:0] sel,
  input  logic [NS-1:0] strobes,
  input  logic [PW-1:0] div,
  output logic          tick
);
  logic [PW-1:0] acc;
  logic          strobe;

  assign strobe = run && strobes[sel];
  assign tick   = strobe && (acc >= div);

  always_ff @(posedge clk) begin
    if (rst || !run)  acc <= '0;
    else if (strobe)  acc <= (acc >= div) ? '0 : acc + 1'b1;
  end

  // R3: a nonzero divider never gives ticks on back-to-back cycles
  assert_div_gap_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && div != '0 && $stable(div)) |=> !tick);
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         tick,
  input  logic         ld,
  input  logic [W-1:0] ld_data,
  input  logic [W-1:0] reload_val,
  input  logic [W-1:0] match,
  input  logic         rsel,
  output logic [W-1:0] cnt,
  output logic         hit
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = cnt;
    if (ld)             nxt = ld_data;
    else if (tick) begin
      if (cnt == '0)    nxt = rsel ? reload_val : '1;
      else              nxt = cnt - 1'b1;
    end
  end

  assign hit = tick && !ld && !clr && (nxt == match);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= nxt;
  end

  // R4: no tick, no load, no clear -> value holds
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ld && !clr) |=> $stable(cnt));
  // R6: free-running wrap
  assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld && !clr && cnt == '0 && !rsel) |=> (cnt == '1));
  // R5: refill at end of count
  assert_refill_R5: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld && !clr && cnt == '0 && rsel) |=> (cnt == $past(reload_val)));
  // R7: a hit leaves the counter on the match value
  assert_hit_R7: assert property (@(posedge clk) disable iff (rst)
    hit |=> (cnt == $past(match)));
endmodule

// File: rtl/cdt_regs.sv
module cdt_regs
  import cdt_pkg::*;
#(
  parameter int RST_CYC = 4,
  localparam int RW = $clog2(RST_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [4:0]    addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic          hit,
  input  logic [DW-1:0] cnt,
  output ctl_t          ctl_q,
  output logic [DW-1:0] load_q,
  output logic [DW-1:0] match_q,
  output logic          flag_q,
  output logic          busy,
  output logic          ld,
  output logic [DW-1:0] ld_data,
  output logic          clr,
  output logic [DW-1:0] rdata
);
  logic [RW-1:0] rst_cnt;
  logic [2:0]    idx;
  logic          aligned, wr_ok, wr_ctl, wr_load, wr_match, wr_stat, start;
  logic          ld_en, ld_wt;
  ctl_t          wctl, keep, clean, rd_ctl;
  logic [DW-1:0] rd_mux;

  assign idx      = addr[4:2];
  assign aligned  = (addr[1:0] == 2'b00);
  assign busy     = (rst_cnt != '0);
  assign wr_ok    = we && aligned && !busy;
  assign wr_ctl   = wr_ok && idx == IDX_CTL;
  assign wr_stat  = wr_ok && idx == IDX_STAT;
  assign wr_load  = wr_ok && idx == IDX_LOAD;
  assign wr_match = wr_ok && idx == IDX_MATCH;
  assign wctl     = ctl_t'(wdata);
  assign start    = wr_ctl && wctl.srst;

  always_comb begin
    keep        = '0;
    keep.lowpwr = ctl_q.lowpwr;
    keep.src    = ctl_q.src;
    clean       = wctl;
    clean.srst  = 1'b0;
    clean.pad   = '0;
  end

  assign ld_en   = wr_ctl && !wctl.srst && wctl.run && wctl.emod && !ctl_q.run;
  assign ld_wt   = wr_load && ctl_q.wthru;
  assign ld      = ld_en || ld_wt;
  assign ld_data = ld_wt ? wdata : load_q;
  assign clr     = start || busy;

  always_comb begin
    rd_ctl      = ctl_q;
    rd_ctl.srst = busy;
    rd_mux      = '0;
    if (aligned) begin
      unique case (idx)
        IDX_CTL:   rd_mux = rd_ctl;
        IDX_STAT:  rd_mux = {{(DW-1){1'b0}}, flag_q};
        IDX_LOAD:  rd_mux = load_q;
        IDX_MATCH: rd_mux = match_q;
        IDX_COUNT: rd_mux = cnt;
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '0;
      load_q  <= '0;
      match_q <= '0;
      flag_q  <= 1'b0;
      rst_cnt <= '0;
      rdata   <= '0;
    end else begin
      if (start) begin
        ctl_q   <= keep;
        load_q  <= '0;
        match_q <= '0;
        rst_cnt <= RW'(RST_CYC);
      end else begin
        if (busy)     rst_cnt <= rst_cnt - 1'b1;
        if (wr_ctl)   ctl_q   <= clean;
        if (wr_load)  load_q  <= wdata;
        if (wr_match) match_q <= wdata;
      end
      if (start)                   flag_q <= 1'b0;
      else if (hit)                flag_q <= 1'b1;
      else if (wr_stat && wdata[0]) flag_q <= 1'b0;
      rdata <= rd_mux;
    end
  end

  // R8: writing 0 to the flag bit keeps it
  assert_w1c_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (flag_q && wr_stat && !wdata[0]) |=> flag_q);
  // R7: flag is sticky without a clearing write or reset
  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !(wr_stat && wdata[0]) && !start) |=> flag_q);
  // R12: during the internal reset the timer is stopped and cleared
  assert_srst_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!ctl_q.run && load_q == '0 && match_q == '0 && !flag_q));
endmodule

// File: rtl/cmp_countdown_timer.sv
module cmp_countdown_timer
  import cdt_pkg::*;
#(
  parameter int RST_CYC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [4:0]      bus_addr,
  input  logic            bus_we,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] src_tick,
  output logic            irq
);
  ctl_t          ctl_q;
  logic [DW-1:0] load_q, match_q, cnt, ld_data;
  logic          flag_q, busy, ld, clr, hit, tick;

  cdt_regs #(.RST_CYC(RST_CYC)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .hit(hit), .cnt(cnt), .ctl_q(ctl_q), .load_q(load_q), .match_q(match_q),
    .flag_q(flag_q), .busy(busy), .ld(ld), .ld_data(ld_data), .clr(clr),
    .rdata(bus_rdata)
  );

  cdt_prescale #(.PW(PRE_W), .NS(NSRC)) u_pre (
    .clk(clk), .rst(rst), .run(ctl_q.run), .sel(ctl_q.src),
    .strobes(src_tick), .div(ctl_q.div), .tick(tick)
  );

  cdt_counter #(.W(DW)) u_cnt (
    .clk(clk), .rst(rst), .clr(clr), .tick(tick), .ld(ld), .ld_data(ld_data),
    .reload_val(load_q), .match(match_q), .rsel(ctl_q.rsel),
    .cnt(cnt), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= flag_q && ctl_q.ie;
  end

  // R9: interrupt follows flag and enable one cycle later
  assert_irq_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(flag_q && ctl_q.ie)));
  // R12: the counter stays cleared while the internal reset runs
  assert_srst_cnt_R12: assert property (@(posedge clk) disable iff (rst)
    busy |=> (cnt == '0));
endmodule

// File: tb/cmp_countdown_timer_bench.sv
module cmp_countdown_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  src_tick = '0;
  logic        irq;
  int errors = 0;
  int checks = 0;
  int cyc = 0;

  cmp_countdown_timer u_cmp_countdown_timer (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_tick(src_tick), .irq(irq)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 50000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    #1 v = bus_rdata;
  endtask

  task automatic pulse(input logic [3:0] m, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); src_tick = m;
      @(negedge clk); src_tick = '0;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 5; a++) begin
      rd(5'(a * 4), v);
      chk("R1 reset register", v, 32'h0);
    end
    chk("R1 reset irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr(5'h00, 32'hFFFE_FFFE);
    rd(5'h00, v); chk("R2 control fields", v, 32'h03FE_FFFE);
    wr(5'h00, 32'h0);
    wr(5'h08, 32'hA5A5_5A5A);
    rd(5'h08, v); chk("R2 reload readback", v, 32'hA5A5_5A5A);
    wr(5'h0C, 32'h1234_5678);
    rd(5'h0C, v); chk("R2 match readback", v, 32'h1234_5678);
    wr(5'h10, 32'h0000_DEAD);
    rd(5'h10, v); chk("R2 counter write ignored", v, 32'h0);
  endtask

  task automatic t_down;
    logic [31:0] v;
    wr(5'h08, 32'd3);
    wr(5'h0C, 32'd0);
    wr(5'h00, 32'h3);
    rd(5'h10, v); chk("R10 refill on enable", v, 32'd3);
    pulse(4'b0001, 2);
    rd(5'h10, v); chk("R4 two ticks", v, 32'd1);
    wr(5'h00, 32'h2);
    pulse(4'b0001, 3);
    rd(5'h10, v); chk("R4 hold while stopped", v, 32'd1);
    wr(5'h00, 32'h1);
    rd(5'h10, v); chk("R10 no refill without mode bit", v, 32'd1);
    pulse(4'b0001, 1);
    rd(5'h04, v); chk("R7 flag on match", v, 32'd1);
    pulse(4'b0001, 1);
    rd(5'h10, v); chk("R6 wrap to all ones", v, 32'hFFFF_FFFF);
    pulse(4'b0001, 1);
    rd(5'h10, v); chk("R6 counts on after wrap", v, 32'hFFFF_FFFE);
    rd(5'h04, v); chk("R7 flag sticky", v, 32'd1);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    chk("R9 irq low while disabled", {31'b0, irq}, 32'h0);
    wr(5'h04, 32'h0);
    rd(5'h04, v); chk("R8 write zero keeps flag", v, 32'd1);
    wr(5'h00, 32'h5);
    rd(5'h00, v); chk("R9 enable readback", v, 32'h5);
    chk("R9 irq raised", {31'b0, irq}, 32'h1);
    wr(5'h04, 32'h1);
    rd(5'h04, v); chk("R8 write one clears", v, 32'd0);
    chk("R9 irq dropped", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_reload;
    logic [31:0] v;
    wr(5'h00, 32'h0);
    wr(5'h08, 32'd2);
    wr(5'h00, 32'hB);
    pulse(4'b0001, 2);
    rd(5'h10, v); chk("R5 reached zero", v, 32'd0);
    rd(5'h04, v); chk("R7 flag at zero", v, 32'd1);
    wr(5'h04, 32'h1);
    pulse(4'b0001, 1);
    rd(5'h10, v); chk("R5 refill from reload", v, 32'd2);
    pulse(4'b0001, 1);
    rd(5'h10, v); chk("R5 after refill", v, 32'd1);
    rd(5'h04, v); chk("R7 no flag off match", v, 32'd0);
  endtask

  task automatic t_pre;
    logic [31:0] v;
    wr(5'h00, 32'h0);
    wr(5'h08, 32'd10);
    wr(5'h00, 32'h2B);
    pulse(4'b0001, 3);
    rd(5'h10, v); chk("R3 divide by three first", v, 32'd9);
    pulse(4'b0001, 5);
    rd(5'h10, v); chk("R3 divide by three partial", v, 32'd8);
    wr(5'h00, 32'h0100_002B);
    pulse(4'b0001, 3);
    rd(5'h10, v); chk("R4 unselected source", v, 32'd8);
    pulse(4'b0010, 3);
    rd(5'h10, v); chk("R4 selected source", v, 32'd7);
  endtask

  task automatic t_wthru;
    logic [31:0] v;
    wr(5'h00, 32'h0002_0000);
    wr(5'h08, 32'h77);
    rd(5'h10, v); chk("R11 write-through", v, 32'h77);
    wr(5'h00, 32'h0);
    wr(5'h08, 32'h55);
    rd(5'h10, v); chk("R11 no write-through", v, 32'h77);
  endtask

  task automatic t_srst;
    logic [31:0] v;
    wr(5'h0C, 32'h3);
    wr(5'h00, 32'h0144_0009);
    wr(5'h00, 32'h0001_0000);
    wr(5'h08, 32'h99);
    rd(5'h00, v); chk("R12 busy on fourth edge", v, 32'h0105_0000);
    rd(5'h00, v); chk("R12 done on fifth edge", v, 32'h0104_0000);
    rd(5'h08, v); chk("R12 reload cleared, write ignored", v, 32'h0);
    rd(5'h0C, v); chk("R12 match cleared", v, 32'h0);
    rd(5'h10, v); chk("R12 counter cleared", v, 32'h0);
    wr(5'h08, 32'h12);
    rd(5'h08, v); chk("R12 writes resume", v, 32'h12);
    wr(5'h09, 32'h34);
    rd(5'h08, v); chk("R2 misaligned write ignored", v, 32'h12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_down();
    t_irq();
    t_reload();
    t_pre();
    t_wthru();
    t_srst();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule